// File: doc/BRIEF.md
# Micro-op Stream Sequencer with Microcode Handoff

This block feeds a downstream consumer from a small store of pre-decoded micro-op lines. The consumer receives up to three micro-ops per cycle on packed lanes. A line holds six slots. Each slot carries either an ordinary micro-op or a tag that stands for a long instruction. When streaming reaches a tag, the sequencer stops reading the line. A computed microcode ROM then supplies the canned sequence that starts at the tag's address. When that sequence ends, streaming resumes at the slot that follows the tag. The consumer sees one continuous stream and cannot tell which source produced each micro-op.

A fetch request names a line. If the line is present, the block enters execute mode and streams it. If the line is absent, the block enters build mode. In build mode it collects decoded micro-ops (and tags) from an input stream and writes the assembled line into the store. It then returns to idle so that the line can be fetched again.

Top module: `uop_stream_seq`

## Requirements
- R1: After reset the block is idle: `fetch_ready` is 1, `bld_ready` is 0, `out_valid` is 0, and every line is absent.
- R2: A fetch accepted while idle enters build mode (`bld_ready`=1 from the next cycle) when the named line is absent. It enters execute mode (`fetch_ready`=0, `bld_ready`=0, micro-ops on the outputs) when the line is present.
- R3: In build mode each `bld_valid` cycle fills the next slot, starting at slot 0. The line is written into the store and the block returns to idle after the sixth slot, or earlier on a slot flagged `bld_last`. Slots left unfilled are invalid, and streaming stops at the first invalid slot.
- R4: In execute mode at most three micro-ops leave per cycle. They are packed from lane 0 upwards in program order, so `out_valid` is one of 000, 001, 011 or 111. Lane k occupies `out_uop[16k+15:16k]`.
- R5: A stored slot is an ordinary micro-op when `bld_tag`=0. It is a ROM tag when `bld_tag`=1, and then bits 4:0 of its 16-bit word are the ROM start address.
- R6: When a cycle's group of slots reaches a tag, only the micro-ops before the tag are delivered in that cycle. ROM output begins in the next cycle that advances.
- R7: ROM entry a holds micro-op 0xC000 | a. Entry a is the last of its sequence when a[1:0] = 11. The ROM delivers up to three entries per cycle and stops after the last one. Trace streaming then resumes at the slot after the tag, or the block goes idle if no slot is left.
- R8: The concatenated output of one fetch equals the line's micro-ops in slot order, with each tag replaced by its ROM sequence.
- R9: While `out_ready` is 0, `out_valid` and `out_uop` hold their values. No micro-op is lost or repeated across a stall.
- R10: Build inputs presented outside build mode are ignored and leave the stored lines unchanged.
- R11: After the last micro-op of a line is accepted, the block returns to idle (`fetch_ready`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_valid | input | 1 | Fetch request, accepted while idle |
| fetch_line | input | LINE_W (2) | Line index to fetch |
| fetch_ready | output | 1 | Block idle, can accept a fetch |
| bld_valid | input | 1 | Build micro-op present |
| bld_uop | input | 16 | Micro-op word, or ROM address for a tag |
| bld_tag | input | 1 | Slot is a ROM tag |
| bld_last | input | 1 | Closes the line after this slot |
| bld_ready | output | 1 | Block in build mode |
| out_valid | output | 3 | Per-lane valid, packed from lane 0 |
| out_uop | output | 48 | Three 16-bit micro-op lanes |
| out_ready | input | 1 | Consumer accepts this cycle's group |

## Verification
The hardest situation to create from the ports is a tag that sits just past a full three-wide group. In that case the trace stops after a full group and the ROM has to take over with no bubble. A second hard case is a tag in the last slot, where ROM completion must end the line rather than resume it. A third is two adjacent tags, one of them at slot 0. The stimulus table builds lines that place tags in exactly these positions. It then streams each line under different back-pressure patterns. Directed tests pin down the per-cycle lane pattern around one handoff, and hold a stall across the first group.

// File: rtl/uop_seq_pkg.sv
package uop_seq_pkg;
  localparam int UOP_W = 16;
  localparam int SLOTS = 6;
  localparam int LANES = 3;
  localparam int PTR_W = $clog2(SLOTS + 1);
  localparam logic [UOP_W-1:0] ROM_BASE = 16'hC000;

  typedef struct packed {
    logic             valid;
    logic             tag;
    logic [UOP_W-1:0] uop;
  } slot_t;

  typedef enum logic [1:0] {S_IDLE, S_TRACE, S_ROM, S_BUILD} seq_state_e;
  typedef enum logic [1:0] {STOP_MORE, STOP_TAG, STOP_END} stop_e;

  // micro-op held by ROM entry at address a
  function automatic logic [UOP_W-1:0] rom_uop(input logic [UOP_W-1:0] a);
    return ROM_BASE | a;
  endfunction

  // a sequence ends on every address whose low two bits are both set
  function automatic logic rom_last(input logic [1:0] a_low);
    return a_low == 2'b11;
  endfunction
endpackage

// File: rtl/uop_trace_store.sv
module uop_trace_store
  import uop_seq_pkg::*;
#(
  parameter int LINES = 4,
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [LINE_W-1:0] wline,
  input  slot_t             wdata [SLOTS],
  input  logic [LINE_W-1:0] rline,
  output slot_t             rdata [SLOTS],
  output logic [LINES-1:0]  present
);
  slot_t mem [LINES][SLOTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present <= '0;
      for (int l = 0; l < LINES; l++)
        for (int s = 0; s < SLOTS; s++) mem[l][s] <= '0;
    end else if (we) begin
      present[wline] <= 1'b1;
      for (int s = 0; s < SLOTS; s++) mem[wline][s] <= wdata[s];
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_rd
    assign rdata[s] = mem[rline][s];
  end

  // R3: a written line is present from the next cycle on
  a_r3_present_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> present[$past(wline)]);
endmodule

// File: rtl/uop_group_pick.sv
module uop_group_pick
  import uop_seq_pkg::*;
#(
  parameter int AW = 5
) (
  input  slot_t                    line [SLOTS],
  input  logic [PTR_W-1:0]         ptr,
  output logic [LANES-1:0]         lane_v,
  output logic [LANES*UOP_W-1:0]   lane_uop,
  output stop_e                    kind,
  output logic [AW-1:0]            tag_addr,
  output logic [PTR_W-1:0]         ptr_next
);
  slot_t            win [LANES+1];
  logic             halted;
  logic [PTR_W-1:0] n;

  // window of the next LANES+1 slots; past the line end reads as invalid
  always_comb begin
    for (int i = 0; i <= LANES; i++) begin
      win[i] = '0;
      for (int j = 0; j < SLOTS; j++)
        if (int'(ptr) + i == j) win[i] = line[j];
    end
  end

  always_comb begin
    halted   = 1'b0;
    kind     = STOP_MORE;
    tag_addr = '0;
    lane_v   = '0;
    lane_uop = '0;
    n        = '0;
    for (int i = 0; i < LANES; i++) begin
      if (!halted) begin
        if (!win[i].valid) begin
          halted = 1'b1;
          kind   = STOP_END;
        end else if (win[i].tag) begin
          halted   = 1'b1;
          kind     = STOP_TAG;
          tag_addr = win[i].uop[AW-1:0];
        end else begin
          lane_v[i] = 1'b1;
          lane_uop[i*UOP_W +: UOP_W] = win[i].uop;
          n = n + PTR_W'(1);
        end
      end
    end
    // lookahead: a full group may still end the line or meet a tag
    if (!halted) begin
      if (!win[LANES].valid) kind = STOP_END;
      else if (win[LANES].tag) begin
        kind     = STOP_TAG;
        tag_addr = win[LANES].uop[AW-1:0];
      end
    end
  end

  assign ptr_next = ptr + n + ((kind == STOP_TAG) ? PTR_W'(1) : PTR_W'(0));
endmodule

// File: rtl/uop_ucode_rom.sv
module uop_ucode_rom
  import uop_seq_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0]          pc,
  output logic [LANES-1:0]       lane_v,
  output logic [LANES*UOP_W-1:0] lane_uop,
  output logic                   seq_end,
  output logic [AW-1:0]          pc_next
);
  logic          stop;
  logic [AW-1:0] a;

  always_comb begin
    stop     = 1'b0;
    lane_v   = '0;
    lane_uop = '0;
    a        = pc;
    for (int i = 0; i < LANES; i++) begin
      a = pc + AW'(i);
      if (!stop) begin
        lane_v[i] = 1'b1;
        lane_uop[i*UOP_W +: UOP_W] = rom_uop(UOP_W'(a));
        if (rom_last(a[1:0])) stop = 1'b1;
      end
    end
    seq_end = stop;
  end

  assign pc_next = pc + AW'(LANES);
endmodule

// File: rtl/uop_stream_seq.sv
module uop_stream_seq
  import uop_seq_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int ROM_AW = 5,
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fetch_valid,
  input  logic [LINE_W-1:0]      fetch_line,
  output logic                   fetch_ready,
  input  logic                   bld_valid,
  input  logic [UOP_W-1:0]       bld_uop,
  input  logic                   bld_tag,
  input  logic                   bld_last,
  output logic                   bld_ready,
  output logic [LANES-1:0]       out_valid,
  output logic [LANES*UOP_W-1:0] out_uop,
  input  logic                   out_ready
);
  seq_state_e        state;
  logic [LINE_W-1:0] cur_line;
  logic [PTR_W-1:0]  ptr;
  logic [PTR_W-1:0]  fill;
  logic [ROM_AW-1:0] rom_pc;
  slot_t             bbuf [SLOTS];

  slot_t                  rd_line [SLOTS];
  slot_t                  wr_line [SLOTS];
  logic [LINES-1:0]       present;
  logic                   store_we;
  slot_t                  new_slot;

  logic [LANES-1:0]       tr_v;
  logic [LANES*UOP_W-1:0] tr_uop;
  stop_e                  tr_kind;
  logic [ROM_AW-1:0]      tr_tag;
  logic [PTR_W-1:0]       tr_ptr_next;

  logic [LANES-1:0]       rm_v;
  logic [LANES*UOP_W-1:0] rm_uop;
  logic                   rm_end;
  logic [ROM_AW-1:0]      rm_pc_next;

  // named events for the assertions
  logic tag_jump, rom_exit, line_end;

  uop_trace_store #(.LINES(LINES)) u_store (
    .clk(clk), .rst_n(rst_n), .we(store_we), .wline(cur_line), .wdata(wr_line),
    .rline(cur_line), .rdata(rd_line), .present(present)
  );

  uop_group_pick #(.AW(ROM_AW)) u_pick (
    .line(rd_line), .ptr(ptr), .lane_v(tr_v), .lane_uop(tr_uop),
    .kind(tr_kind), .tag_addr(tr_tag), .ptr_next(tr_ptr_next)
  );

  uop_ucode_rom #(.AW(ROM_AW)) u_rom (
    .pc(rom_pc), .lane_v(rm_v), .lane_uop(rm_uop), .seq_end(rm_end), .pc_next(rm_pc_next)
  );

  assign fetch_ready = (state == S_IDLE);
  assign bld_ready   = (state == S_BUILD);

  always_comb begin
    out_valid = '0;
    out_uop   = '0;
    if (state == S_TRACE) begin
      out_valid = tr_v;
      out_uop   = tr_uop;
    end else if (state == S_ROM) begin
      out_valid = rm_v;
      out_uop   = rm_uop;
    end
  end

  assign tag_jump = (state == S_TRACE) && out_ready && (tr_kind == STOP_TAG);
  assign rom_exit = (state == S_ROM) && out_ready && rm_end;
  assign line_end = ((state == S_TRACE) && out_ready && (tr_kind == STOP_END)) ||
                    (rom_exit && (ptr >= PTR_W'(SLOTS)));

  // build path: merge the incoming slot into the line being assembled
  assign new_slot = '{valid: 1'b1, tag: bld_tag, uop: bld_uop};
  assign store_we = (state == S_BUILD) && bld_valid &&
                    (bld_last || (fill == PTR_W'(SLOTS - 1)));

  always_comb begin
    for (int j = 0; j < SLOTS; j++)
      wr_line[j] = (PTR_W'(j) == fill) ? new_slot : bbuf[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cur_line <= '0;
      ptr      <= '0;
      fill     <= '0;
      rom_pc   <= '0;
      for (int j = 0; j < SLOTS; j++) bbuf[j] <= '0;
    end else begin
      case (state)
        S_IDLE: if (fetch_valid) begin
          cur_line <= fetch_line;
          ptr      <= '0;
          fill     <= '0;
          for (int j = 0; j < SLOTS; j++) bbuf[j] <= '0;
          state    <= present[fetch_line] ? S_TRACE : S_BUILD;
        end
        S_TRACE: if (out_ready) begin
          case (tr_kind)
            STOP_TAG: begin
              ptr    <= tr_ptr_next;
              rom_pc <= tr_tag;
              state  <= S_ROM;
            end
            STOP_END: state <= S_IDLE;
            default:  ptr <= tr_ptr_next;
          endcase
        end
        S_ROM: if (out_ready) begin
          if (rm_end) state <= (ptr >= PTR_W'(SLOTS)) ? S_IDLE : S_TRACE;
          else        rom_pc <= rm_pc_next;
        end
        S_BUILD: if (bld_valid) begin
          for (int j = 0; j < SLOTS; j++)
            if (PTR_W'(j) == fill) bbuf[j] <= new_slot;
          fill <= fill + PTR_W'(1);
          if (store_we) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R4: lanes are packed from lane 0
  a_r4_packed_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid & (out_valid + LANES'(1))) == '0);
  // R6: reaching a tag hands over to the ROM, which emits in the next cycle
  a_r6_tag_to_rom: assert property (@(posedge clk) disable iff (!rst_n)
    tag_jump |=> (state == S_ROM) && (out_valid != '0));
  // R7: the end of a ROM sequence leaves ROM mode
  a_r7_rom_return: assert property (@(posedge clk) disable iff (!rst_n)
    rom_exit |=> (state != S_ROM));
  // R9: a stalled group holds still
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_ready && (out_valid != '0)) |=> $stable(out_valid) && $stable(out_uop));
  // R11: the end of a line returns to idle
  a_r11_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> fetch_ready);
  // R3: a store write closes build mode
  a_r3_close_build: assert property (@(posedge clk) disable iff (!rst_n)
    store_we |=> fetch_ready && !bld_ready);
endmodule

// File: tb/uop_stream_seq_tb.sv
module uop_stream_seq_tb;
  localparam int NV = 4;
  localparam int NS = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_valid;
  logic [1:0]  fetch_line;
  logic        fetch_ready;
  logic        bld_valid;
  logic [15:0] bld_uop;
  logic        bld_tag;
  logic        bld_last;
  logic        bld_ready;
  logic [2:0]  out_valid;
  logic [47:0] out_uop;
  logic        out_ready;

  always #5 clk = ~clk;

  uop_stream_seq u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_line(fetch_line),
    .fetch_ready(fetch_ready), .bld_valid(bld_valid), .bld_uop(bld_uop), .bld_tag(bld_tag),
    .bld_last(bld_last), .bld_ready(bld_ready), .out_valid(out_valid), .out_uop(out_uop),
    .out_ready(out_ready)
  );

  // slot code: bit17 valid, bit16 tag (R5), bits 15:0 micro-op or ROM address
  localparam logic [17:0] VSLOT [NV][NS] = '{
    '{18'h21001, 18'h21002, 18'h21003, 18'h21004, 18'h21005, 18'h21006},
    '{18'h22001, 18'h30004, 18'h22002, 18'h22003, 18'h00000, 18'h00000},
    '{18'h30006, 18'h30001, 18'h23001, 18'h00000, 18'h00000, 18'h00000},
    '{18'h24001, 18'h24002, 18'h24003, 18'h30008, 18'h24004, 18'h3000D}
  };
  localparam int VCNT  [NV] = '{6, 4, 3, 6};
  localparam int VMODE [NV] = '{0, 1, 0, 2};

  int nchk = 0;
  int nerr = 0;
  logic [15:0] got [128];
  logic [15:0] expv [128];
  logic [2:0]  cyc_v [64];
  logic [15:0] cyc_u [64];
  int ngot, nexp, ncyc;

  task automatic chk(input string req, input logic [47:0] actual, input logic [47:0] expected);
    nchk++;
    if (actual !== expected) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  // expected stream: slot order, each tag expanded to C000|a until a[1:0]==3
  task automatic make_exp(input int v);
    logic [17:0] s;
    int a;
    nexp = 0;
    for (int k = 0; k < VCNT[v]; k++) begin
      s = VSLOT[v][k];
      if (s[16]) begin
        a = int'(s[4:0]);
        for (int g = 0; g < 32; g++) begin
          expv[nexp] = 16'hC000 | 16'(a);
          nexp++;
          if (a % 4 == 3) break;
          a++;
        end
      end else begin
        expv[nexp] = s[15:0];
        nexp++;
      end
    end
  endtask

  task automatic pulse_fetch(input int ln);
    fetch_valid = 1'b1;
    fetch_line  = 2'(ln);
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  task automatic build_line(input int v);
    pulse_fetch(v);
    chk("R2 build entered", {47'd0, bld_ready}, 48'd1);
    for (int k = 0; k < VCNT[v]; k++) begin
      bld_valid = 1'b1;
      bld_tag   = VSLOT[v][k][16];
      bld_uop   = VSLOT[v][k][15:0];
      bld_last  = (k == VCNT[v] - 1) && (VCNT[v] < NS);
      @(negedge clk);
    end
    bld_valid = 1'b0;
    bld_last  = 1'b0;
    chk("R3 line closed", {47'd0, fetch_ready}, 48'd1);
  endtask

  // collect from the current negedge until idle, ready shaped by mode
  task automatic collect(input int mode);
    int guard;
    ngot = 0; ncyc = 0; guard = 0;
    while (!fetch_ready && guard < 400) begin
      case (mode)
        0:       out_ready = 1'b1;
        1:       out_ready = (guard % 2 == 0);
        default: out_ready = (guard % 3 != 2);
      endcase
      if (out_valid != 3'b000)
        chk("R4 lanes packed", {47'd0, (out_valid & (out_valid + 3'd1)) == 3'd0}, 48'd1);
      if (out_ready && out_valid != 3'b000) begin
        if (ncyc < 64) begin
          cyc_v[ncyc] = out_valid;
          cyc_u[ncyc] = out_uop[15:0];
        end
        ncyc++;
        for (int l = 0; l < 3; l++)
          if (out_valid[l] && ngot < 128) begin
            got[ngot] = out_uop[l*16 +: 16];
            ngot++;
          end
      end
      guard++;
      @(negedge clk);
    end
    out_ready = 1'b1;
    chk("R11 returned to idle", {47'd0, guard < 400}, 48'd1);
  endtask

  task automatic compare_stream(input string req);
    chk(req, 48'(ngot), 48'(nexp));
    for (int k = 0; k < nexp && k < ngot; k++) chk(req, 48'(got[k]), 48'(expv[k]));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  initial begin
    logic [2:0]  hv;
    logic [47:0] hu;
    rst_n = 1'b0; fetch_valid = 1'b0; fetch_line = '0;
    bld_valid = 1'b0; bld_uop = '0; bld_tag = 1'b0; bld_last = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 fetch_ready", {47'd0, fetch_ready}, 48'd1);
    chk("R1 bld_ready", {47'd0, bld_ready}, 48'd0);
    chk("R1 out_valid", {45'd0, out_valid}, 48'd0);

    // table walk: build each line, then stream it (R3, R5, R7, R8)
    for (int v = 0; v < NV; v++) begin
      build_line(v);
      make_exp(v);
      pulse_fetch(v);
      chk("R2 execute entered", {46'd0, fetch_ready, bld_ready}, 48'd0);
      collect(VMODE[v]);
      compare_stream("R8 stream");
    end

    // R6/R7 cycle pattern on line 1: 001 | 111 | 001 | 011
    make_exp(1);
    pulse_fetch(1);
    collect(0);
    chk("R6 cycle count", 48'(ncyc), 48'd4);
    chk("R6 group before tag", 48'(cyc_v[0]), 48'b001);
    chk("R6 first lane before tag", 48'(cyc_u[0]), 48'h2001);
    chk("R7 rom group", 48'(cyc_v[1]), 48'b111);
    chk("R7 rom first", 48'(cyc_u[1]), 48'hC004);
    chk("R7 rom tail", 48'(cyc_v[2]), 48'b001);
    chk("R7 rom end uop", 48'(cyc_u[2]), 48'hC007);
    chk("R7 resume after tag", 48'(cyc_u[3]), 48'h2002);
    chk("R7 resume lanes", 48'(cyc_v[3]), 48'b011);

    // R9 stall on the first group of line 0
    make_exp(0);
    out_ready = 1'b0;
    pulse_fetch(0);
    hv = out_valid;
    hu = out_uop;
    chk("R9 stalled group", 48'(hv), 48'b111);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R9 valid held", 48'(out_valid), 48'(hv));
      chk("R9 data held", out_uop, hu);
    end
    collect(0);
    compare_stream("R9 no loss");

    // R10 build inputs while idle are ignored
    for (int k = 0; k < 3; k++) begin
      bld_valid = 1'b1; bld_uop = 16'hDEAD; bld_tag = 1'b1; bld_last = 1'b1;
      @(negedge clk);
      chk("R10 stays idle", {46'd0, fetch_ready, bld_ready}, 48'b10);
    end
    bld_valid = 1'b0; bld_last = 1'b0; bld_tag = 1'b0;
    make_exp(0);
    pulse_fetch(0);
    collect(1);
    compare_stream("R10 line unchanged");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule